// File: doc/BRIEF.md
# Receive Line Interface Sampler with Bipolar Violation Counter

This block takes the serial receive stream from an external line interface unit and turns it into a plain NRZ bit stream with a per-bit valid pulse. It supports two input conventions. In dual-rail mode the two line inputs carry positive and negative marks of an alternate-mark-inversion signal. In binary mode the first input carries NRZ data and the second carries a line-code-violation flag. Each input has its own polarity inversion control. The active edge of the receive line clock is selectable.

The receive line clock may be gapped and may run at up to 52 MHz. It is not used as a clock. It is sampled as a level on a faster system clock, and each selected edge produces a one-cycle sampling strobe. Data recovery and violation counting happen only on those strobes.

A 16-bit saturating violation counter collects bipolar violations. A latch strobe copies the count into two byte-wide read registers and restarts the count in the same cycle. A violation that arrives in the latch cycle is not lost.

Top module: `rx_line_if`

## Requirements
- R1: In dual-rail mode (`binary_i`=0), a sampled bit with a mark on either effective rail gives `data_o`=1. A bit with no mark gives `data_o`=0. Both rails marked also gives 1.
- R2: In binary mode (`binary_i`=1), `data_o` equals the effective positive input, and the negative input is used only as the violation flag.
- R3: A selected line-clock edge is the rising edge of `line_clk_i` when `clk_inv_i`=0 and the falling edge when `clk_inv_i`=1. An edge is seen in a system clock cycle when `line_clk_i` differs from its value at the previous system clock edge. Each selected edge gives exactly one `valid_o` pulse, with `data_o` updated, on the following system clock edge. Edges of the other polarity give no pulse.
- R4: `pos_inv_i`=1 inverts `pos_i`, and `neg_inv_i`=1 inverts `neg_i`, before decoding. This applies in both modes.
- R5: In binary mode, the counter increments once for each selected edge on which `neg_i` is 1 when `neg_inv_i`=0. When `neg_inv_i`=1, it increments when `neg_i` is 0.
- R6: In dual-rail mode, a mark with the same polarity as the previous single-rail mark counts one violation. The first mark after reset does not count, and zeros in between do not clear the remembered polarity. Both rails marked counts one violation and leaves the remembered polarity unchanged.
- R7: The violation count saturates at 0xFFFF and does not wrap.
- R8: When `latch_i` is 1 at a system clock edge, `cnt_hi_o`/`cnt_lo_o` take bits 15:8 and 7:0 of the count held before that edge. The count restarts at 1 if a violation is counted in that cycle, and at 0 otherwise.
- R9: With no selected edge, `valid_o` stays 0, `data_o` holds its value and the count does not change, whatever the line inputs do.
- R10: Asynchronous reset clears `data_o`, `valid_o`, the count, both read registers and the remembered polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_clk_i | input | 1 | Receive line clock level, synchronous to clk_i, may be gapped |
| pos_i | input | 1 | Positive rail, or NRZ data in binary mode |
| neg_i | input | 1 | Negative rail, or violation flag in binary mode |
| binary_i | input | 1 | 0 selects dual-rail, 1 selects binary |
| clk_inv_i | input | 1 | 0 samples on rising line-clock edge, 1 on falling |
| pos_inv_i | input | 1 | Inverts pos_i |
| neg_inv_i | input | 1 | Inverts neg_i |
| latch_i | input | 1 | Copy count into read registers and restart count |
| data_o | output | 1 | Recovered NRZ bit |
| valid_o | output | 1 | One-cycle pulse per sampled bit |
| cnt_hi_o | output | 8 | Latched count, high byte |
| cnt_lo_o | output | 8 | Latched count, low byte |

## Verification
A stale or wrong edge register shows up one system cycle after the first line-clock transition, as a missing, extra or doubled `valid_o` pulse. A bad polarity memory or a wrong violation decode is invisible on `data_o`. It appears only at the next latch, as a count that differs from the one the bench computes from the symbol sequence it drove. Counter faults at the limits (wrap instead of saturation, or an increment lost in the latch cycle) show up in the first read after a run past 0xFFFF, or in the read right after a latch that coincided with a violation.

// File: rtl/rx_line_pkg.sv
package rx_line_pkg;
  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_POS  = 2'd1,
    POL_NEG  = 2'd2
  } mark_pol_e;
endpackage

// File: rtl/rx_edge_sel.sv
module rx_edge_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_clk_i,
  input  logic inv_i,
  output logic strobe_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= line_clk_i;
  end

  assign rise     = line_clk_i & ~prev_q;
  assign fall     = ~line_clk_i & prev_q;
  assign strobe_o = inv_i ? fall : rise;
endmodule

// File: rtl/rx_line_decode.sv
module rx_line_decode
  import rx_line_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic binary_i,
  input  logic pos_i,
  input  logic neg_i,
  input  logic pos_inv_i,
  input  logic neg_inv_i,
  output logic data_o,
  output logic valid_o,
  output logic viol_o
);
  mark_pol_e last_q, last_d;
  logic p_eff, n_eff;
  logic bit_d, viol_d;

  assign p_eff = pos_i ^ pos_inv_i;
  assign n_eff = neg_i ^ neg_inv_i;

  always_comb begin
    last_d = last_q;
    bit_d  = 1'b0;
    viol_d = 1'b0;
    if (binary_i) begin
      bit_d  = p_eff;
      viol_d = n_eff;
    end else begin
      bit_d = p_eff | n_eff;
      unique case ({p_eff, n_eff})
        2'b11: viol_d = 1'b1;  // both rails: violation, memory kept
        2'b10: begin
          viol_d = (last_q == POL_POS);
          last_d = POL_POS;
        end
        2'b01: begin
          viol_d = (last_q == POL_NEG);
          last_d = POL_NEG;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= POL_NONE;
      data_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        data_o <= bit_d;
        if (!binary_i) last_q <= last_d;
      end
    end
  end

  assign viol_o = strobe_i & viol_d;
endmodule

// File: rtl/rx_viol_counter.sv
module rx_viol_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              latch_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [2*BYTE_W-1:0] count_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_o  <= '0;
      lo_o  <= '0;
    end else begin
      if (latch_i) begin
        hi_o  <= cnt_q[CNT_W-1:BYTE_W];
        lo_o  <= cnt_q[BYTE_W-1:0];
        cnt_q <= {{(CNT_W-1){1'b0}}, inc_i};
      end else if (inc_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/rx_line_if.sv
module rx_line_if #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_clk_i,
  input  logic              pos_i,
  input  logic              neg_i,
  input  logic              binary_i,
  input  logic              clk_inv_i,
  input  logic              pos_inv_i,
  input  logic              neg_inv_i,
  input  logic              latch_i,
  output logic              data_o,
  output logic              valid_o,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic [BYTE_W-1:0] cnt_lo_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             strobe;
  logic             viol;
  logic [CNT_W-1:0] viol_count;

  rx_edge_sel u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_clk_i (line_clk_i),
    .inv_i      (clk_inv_i),
    .strobe_o   (strobe)
  );

  rx_line_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .binary_i  (binary_i),
    .pos_i     (pos_i),
    .neg_i     (neg_i),
    .pos_inv_i (pos_inv_i),
    .neg_inv_i (neg_inv_i),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .viol_o    (viol)
  );

  rx_viol_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (viol),
    .latch_i (latch_i),
    .hi_o    (cnt_hi_o),
    .lo_o    (cnt_lo_o),
    .count_o (viol_count)
  );
endmodule

// File: rtl/rx_line_if_chk.sv
module rx_line_if_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_clk_i,
  input logic              pos_i,
  input logic              neg_i,
  input logic              binary_i,
  input logic              clk_inv_i,
  input logic              pos_inv_i,
  input logic              neg_inv_i,
  input logic              latch_i,
  input logic              data_o,
  input logic              valid_o,
  input logic [BYTE_W-1:0] cnt_hi_o,
  input logic [BYTE_W-1:0] cnt_lo_o,
  input logic [2*BYTE_W-1:0] count_i
);
  localparam logic [2*BYTE_W-1:0] MAXC = {(2*BYTE_W){1'b1}};

  logic lc_prev;
  logic sel_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lc_prev <= 1'b0;
    else         lc_prev <= line_clk_i;
  end

  assign sel_edge = clk_inv_i ? (lc_prev && !line_clk_i) : (!lc_prev && line_clk_i);

  a_r3_edge_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_edge |=> valid_o);
  a_r3_no_edge_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_edge |=> !valid_o);
  a_r9_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_edge |=> $stable(data_o));
  a_r2_binary_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_edge && binary_i) |=> data_o == $past(pos_i ^ pos_inv_i));
  a_r5_binary_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_edge && binary_i && (neg_i ^ neg_inv_i) && !latch_i && count_i != MAXC)
      |=> count_i == $past(count_i) + 1'b1);
  a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == MAXC && !latch_i) |=> count_i == MAXC);
  a_r8_latch_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> {cnt_hi_o, cnt_lo_o} == $past(count_i));
  a_r8_latch_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> count_i <= 1);
endmodule

bind rx_line_if rx_line_if_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_clk_i (line_clk_i),
  .pos_i      (pos_i),
  .neg_i      (neg_i),
  .binary_i   (binary_i),
  .clk_inv_i  (clk_inv_i),
  .pos_inv_i  (pos_inv_i),
  .neg_inv_i  (neg_inv_i),
  .latch_i    (latch_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .cnt_hi_o   (cnt_hi_o),
  .cnt_lo_o   (cnt_lo_o),
  .count_i    (viol_count)
);

// File: tb/rx_line_if_tb.sv
module rx_line_if_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_clk = 1'b0, pos = 1'b0, neg = 1'b0;
  logic binary = 1'b0, cinv = 1'b0, pinv = 1'b0, ninv = 1'b0, latch = 1'b0;
  logic data, valid;
  logic [7:0] hi, lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  rx_line_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_clk_i(line_clk), .pos_i(pos), .neg_i(neg),
    .binary_i(binary), .clk_inv_i(cinv), .pos_inv_i(pinv), .neg_inv_i(ninv),
    .latch_i(latch), .data_o(data), .valid_o(valid), .cnt_hi_o(hi), .cnt_lo_o(lo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; latch = 1'b0;
    line_clk = cinv;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // logical p/n are pre-inversion values; bench drives raw pins accordingly
  task automatic send(input logic p, input logic n, output logic v, output logic d);
    @(negedge clk);
    line_clk = cinv; pos = ~(p ^ pinv); neg = ~(n ^ ninv);
    @(negedge clk);
    check("R3 opposite edge no valid", valid, 0);
    line_clk = ~cinv; pos = p ^ pinv; neg = n ^ ninv;
    @(negedge clk);
    v = valid; d = data;
  endtask

  task automatic read_cnt(output int c);
    @(negedge clk); latch = 1'b1;
    @(negedge clk); latch = 1'b0;
    c = {hi, lo};
  endtask

  // dual-rail sequence with bench model of polarity memory
  task automatic ami_run(input int nsym);
    logic [7:0] lf = 8'hA5;
    int mem = 0, vcnt = 0, c;
    logic v, d;
    for (int i = 0; i < nsym; i++) begin
      int s;
      logic ev;
      s = lf[1:0];
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      ev = (s == 3) || (s == 1 && mem == 1) || (s == 2 && mem == 2);
      if (s == 1) mem = 1;
      if (s == 2) mem = 2;
      if (ev) vcnt++;
      send(s[0], s[1], v, d);
      check("R3 valid on selected edge", v, 1);
      check("R1 R4 dual-rail decode", d, (s != 0) ? 1 : 0);
    end
    read_cnt(c);
    check("R6 R4 dual-rail violation count", c, vcnt);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic v, d;
    int c;
    repeat (2) @(negedge clk);
    check("R10 reset valid", valid, 0);
    check("R10 reset data", data, 0);
    check("R10 reset count regs", {hi, lo}, 0);
    rst_n = 1'b1;

    // R6: fixed sequence P, 0, P(viol), N, N(viol), B(viol), N(viol since memory kept)
    send(1, 0, v, d); send(0, 0, v, d); send(1, 0, v, d);
    send(0, 1, v, d); send(0, 1, v, d); send(1, 1, v, d);
    check("R1 both rails decode one", d, 1);
    send(0, 1, v, d);
    read_cnt(c);
    check("R6 fixed pattern count", c, 4);

    // R3/R9 gap: idle cycles with toggling data, no selected edge
    @(negedge clk); line_clk = ~cinv;
    begin
      logic d0;
      d0 = data;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); pos = ~pos; neg = ~neg;
        check("R9 gap no valid", valid, 0);
        check("R9 gap data held", data, d0);
      end
      read_cnt(c);
      check("R9 gap no count", c, 0);
    end

    // dual-rail sweeps: rising edge plain, falling edge inverted
    do_reset(); ami_run(40);
    cinv = 1'b1; pinv = 1'b1; ninv = 1'b1;
    do_reset(); ami_run(40);

    // binary exhaustive over p, n, pinv, ninv, both edges
    binary = 1'b1;
    for (int k = 0; k < 32; k++) begin
      logic p, n;
      p = k[0]; n = k[1]; pinv = k[2]; ninv = k[3]; cinv = k[4];
      do_reset();
      send(p, n, v, d);
      check("R3 binary valid", v, 1);
      check("R2 R4 binary data", d, p);
      read_cnt(c);
      check("R5 binary violation count", c, n);
    end

    // R8: latch coinciding with a counted violation
    cinv = 1'b0; pinv = 1'b0; ninv = 1'b0;
    do_reset();
    for (int i = 0; i < 3; i++) send(0, 1, v, d);
    @(negedge clk); line_clk = 1'b0; neg = 1'b1;
    @(negedge clk); line_clk = 1'b1; latch = 1'b1;
    @(negedge clk); latch = 1'b0;
    check("R8 snapshot before increment", {hi, lo}, 3);
    read_cnt(c);
    check("R8 increment kept after latch", c, 1);

    // R5 with invert: neg low counts
    ninv = 1'b1;
    send(0, 1, v, d); send(0, 1, v, d); send(0, 0, v, d);
    read_cnt(c);
    check("R5 inverted flag count", c, 2);

    // R7: run past the limit, also checks high byte path
    ninv = 1'b0; neg = 1'b1;
    do_reset();
    for (int i = 0; i < 2 * 300; i++) begin
      @(negedge clk); line_clk = ~line_clk;
    end
    read_cnt(c);
    check("R8 high byte count", c, 300);
    for (int i = 0; i < 2 * 65800; i++) begin
      @(negedge clk); line_clk = ~line_clk;
    end
    read_cnt(c);
    check("R7 saturation", c, 65535);
    read_cnt(c);
    check("R8 cleared after latch", c, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule